// File: doc/BRIEF.md
# Three-Bank GPIO Controller with Edge and Level Detection

This peripheral drives and samples 96 general-purpose pins, organised as three banks of 32. Software reaches it through a single-cycle register port: an address, a write strobe, write data and combinational read data. Each pin has a direction bit. Output pins are updated by write-one set and clear registers or by a direct write of the whole output word. Input pins pass through a two-flop synchroniser and an optional per-pin inversion before they are read back or fed to detection.

Every pin can watch for a rising edge, a falling edge, a high level or a low level, with an enable register for each kind. A detection event sets a sticky pending bit, and software clears it by writing ones to it. A companion register records whether an edge caused the pending bit. One interrupt line is raised while any pending bit in any bank is set.

The register port is a control interface. It has no handshake: every access completes in the cycle it is presented.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pad_out` and `pad_oe` are all zero, and `irq` is low.
- R2: Byte address = register index × 0x10 + bank × 0x4. The banks are 0..2 and the indices are 0..10. Accesses to bank 3, to index 11 or above, or to an address whose two low bits are not zero read zero and change nothing.
- R3: Index 0 (direction) holds one bit per pin, and a 1 makes the pin an output. `pad_oe` for a bank equals its direction register from the cycle after the write.
- R4: The output word of a bank appears on `pad_out`. Writing index 2 loads the word directly. At index 3, each 1 bit sets the matching output. At index 4, each 1 bit clears it. A 0 bit in a set or clear write leaves that output unchanged.
- R5: Reading index 2 returns the output word on output pins and the synchronised, inversion-adjusted pad level on input pins. A pad change first shows in this value after two rising clock edges.
- R6: Index 1 (inversion) flips a pin's sampled level, both for the index 2 readback and for detection.
- R7: Index 5 enables rising-edge detection and index 6 enables falling-edge detection. On an enabled pin, a pad transition sets its pending bit (index 9) on the third rising edge after the change. Transitions on pins without the enable set nothing.
- R8: Writing index 9 clears exactly the pending bits written as 1. Pending bits stay set until they are cleared this way.
- R9: If a detection event and a clearing write reach the same pending bit in the same cycle, the bit stays set.
- R10: Index 7 enables high-level detection and index 8 enables low-level detection. While the enabled level persists, the pending bit is set again every cycle, so a clear does not hold.
- R11: Index 10 (read-only) has a bit set when an edge event set the pending bit. It clears together with the pending bit and is not set by level events.
- R12: `irq` is high exactly when at least one pending bit in any bank is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | 96 | Pad levels, pin n at bit n |
| pad_out | output | 96 | Output values |
| pad_oe | output | 96 | Output enables |
| irq | output | 1 | Combined pending interrupt |

## Verification
The bench aims a clearing write at the exact cycle in which an edge event lands. A design that gives clear priority would lose that event. It measures the two-edge readback delay and the three-edge detection delay by reading at the cycles just before and at the change, which exposes a missing or an extra synchroniser stage. Level detection is cleared while the level persists and again after the enable drops. A design that treats levels as one-shot would read zero too early, and one that ignores the enable would never clear. Inverted pins, disabled edge kinds, bank 3, index 11 and a misaligned address each probe a decode or gating slip that would mark the wrong pin or write the wrong bank.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int IDX_W = 4;

  // Register index; address = index*0x10 + bank*0x4
  typedef enum logic [IDX_W-1:0] {
    RI_DIR  = 4'd0,
    RI_INV  = 4'd1,
    RI_LVL  = 4'd2,
    RI_SET  = 4'd3,
    RI_CLR  = 4'd4,
    RI_REN  = 4'd5,
    RI_FEN  = 4'd6,
    RI_HEN  = 4'd7,
    RI_LEN  = 4'd8,
    RI_PEND = 4'd9,
    RI_KIND = 4'd10
  } reg_idx_e;

  localparam logic [IDX_W-1:0] LAST_IDX = RI_KIND;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[s] <= '0;
      end else if (s == 0) begin
        stg[s] <= d;
      end else begin
        stg[s] <= stg[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_oe,
  output logic [W-1:0]     pend_bits,
  output logic             pend_any
);
  logic [W-1:0] dir_q, inv_q, out_q;
  logic [W-1:0] ren_q, fen_q, hen_q, len_q;
  logic [W-1:0] pend_q, kind_q, prev_q;
  logic [W-1:0] syn, lvl, rise, fall, edge_hit, lvl_hit, clr;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (syn)
  );

  // Sampled level after optional inversion
  assign lvl      = syn ^ inv_q;
  assign rise     = lvl & ~prev_q;
  assign fall     = ~lvl & prev_q;
  assign edge_hit = (rise & ren_q) | (fall & fen_q);
  assign lvl_hit  = (lvl & hen_q) | (~lvl & len_q);
  assign clr      = (wr_en && wr_idx == RI_PEND) ? wr_data : '0;

  // Configuration and output word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      inv_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      hen_q <= '0;
      len_q <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        RI_DIR: dir_q <= wr_data;
        RI_INV: inv_q <= wr_data;
        RI_LVL: out_q <= wr_data;
        RI_SET: out_q <= out_q | wr_data;
        RI_CLR: out_q <= out_q & ~wr_data;
        RI_REN: ren_q <= wr_data;
        RI_FEN: fen_q <= wr_data;
        RI_HEN: hen_q <= wr_data;
        RI_LEN: len_q <= wr_data;
        default: ;
      endcase
    end
  end

  // Sticky pending and edge-origin bits; a new event beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      kind_q <= '0;
      prev_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | edge_hit | lvl_hit;
      kind_q <= (kind_q & ~clr) | edge_hit;
      prev_q <= lvl;
    end
  end

  always_comb begin
    case (rd_idx)
      RI_DIR:  rd_data = dir_q;
      RI_INV:  rd_data = inv_q;
      RI_LVL:  rd_data = (dir_q & out_q) | (~dir_q & lvl);
      RI_REN:  rd_data = ren_q;
      RI_FEN:  rd_data = fen_q;
      RI_HEN:  rd_data = hen_q;
      RI_LEN:  rd_data = len_q;
      RI_PEND: rd_data = pend_q;
      RI_KIND: rd_data = kind_q;
      default: rd_data = '0;
    endcase
  end

  assign pin_out   = out_q;
  assign pin_oe    = dir_q;
  assign pend_bits = pend_q;
  assign pend_any  = |pend_q;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_we,
  input  logic [BANK_W-1:0]           reg_wdata,
  output logic [BANK_W-1:0]           reg_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] pad_in,
  output logic [NUM_BANKS*BANK_W-1:0] pad_out,
  output logic [NUM_BANKS*BANK_W-1:0] pad_oe,
  output logic                        irq
);
  localparam int PINS     = NUM_BANKS * BANK_W;
  localparam int BANK_LSB = 2;
  localparam int BANK_FW  = 2;
  localparam int IDX_LSB  = BANK_LSB + BANK_FW;
  localparam int TOP_LSB  = IDX_LSB + IDX_W;

  logic [BANK_FW-1:0] sel_bank;
  logic [IDX_W-1:0]   sel_idx;
  logic               hi_zero, addr_ok;
  logic [NUM_BANKS-1:0] bank_wr, pend_vec;
  logic [BANK_W-1:0]  bank_rd [NUM_BANKS];
  logic [PINS-1:0]    stat_all;

  assign sel_bank = reg_addr[IDX_LSB-1:BANK_LSB];
  assign sel_idx  = reg_addr[TOP_LSB-1:IDX_LSB];

  if (ADDR_W > TOP_LSB) begin : g_hi
    assign hi_zero = (reg_addr[ADDR_W-1:TOP_LSB] == '0);
  end else begin : g_nohi
    assign hi_zero = 1'b1;
  end

  assign addr_ok = hi_zero && (reg_addr[BANK_LSB-1:0] == '0) && (sel_idx <= LAST_IDX);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_wr[b] = reg_we && addr_ok && (sel_bank == BANK_FW'(b));

    gpio_bank #(.W(BANK_W), .SYNC_STAGES(SYNC_STAGES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bank_wr[b]),
      .wr_idx   (sel_idx),
      .wr_data  (reg_wdata),
      .rd_idx   (sel_idx),
      .rd_data  (bank_rd[b]),
      .pin_in   (pad_in[b*BANK_W +: BANK_W]),
      .pin_out  (pad_out[b*BANK_W +: BANK_W]),
      .pin_oe   (pad_oe[b*BANK_W +: BANK_W]),
      .pend_bits(stat_all[b*BANK_W +: BANK_W]),
      .pend_any (pend_vec[b])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_ok && sel_bank == BANK_FW'(b)) reg_rdata = bank_rd[b];
    end
  end

  assign irq = |pend_vec;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic                        reg_we,
  input logic [BANK_W-1:0]           reg_wdata,
  input logic [NUM_BANKS*BANK_W-1:0] pad_out,
  input logic [NUM_BANKS*BANK_W-1:0] pad_oe,
  input logic                        irq,
  input logic [NUM_BANKS*BANK_W-1:0] stat_all
);
  localparam int PEND_OFS = int'(RI_PEND) * 16;

  // R1: reset leaves pads released and interrupt low
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_out == '0 && !irq));

  // R12: combined line tracks the pending bits of all banks
  p_irq_any_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|stat_all));

  // R8: without a write to a pending register the line cannot drop
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_we && reg_addr >= ADDR_W'(PEND_OFS) && reg_addr < ADDR_W'(PEND_OFS + 16)))
    |=> irq);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(int'(RI_DIR) * 16 + b * 4);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(int'(RI_SET) * 16 + b * 4);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(int'(RI_CLR) * 16 + b * 4);

    // R3: output enables follow the direction write
    p_oe_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_DIR) |=> pad_oe[b*BANK_W +: BANK_W] == $past(reg_wdata));

    // R4: set write only raises bits
    p_set_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_SET) |=>
        pad_out[b*BANK_W +: BANK_W] == ($past(pad_out[b*BANK_W +: BANK_W]) | $past(reg_wdata)));

    // R4: clear write only lowers bits
    p_clr_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_CLR) |=>
        pad_out[b*BANK_W +: BANK_W] == ($past(pad_out[b*BANK_W +: BANK_W]) & ~$past(reg_wdata)));
  end
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_we   (reg_we),
  .reg_wdata(reg_wdata),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .irq      (irq),
  .stat_all (stat_all)
);

// File: tb/gpio_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_ctrl_bench;
  localparam int NB = 3;
  localparam int BW = 32;

  localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_PIN = 3'd2,
                         K_OUT = 3'd3, K_OE = 3'd4, K_IRQ = 3'd5;

  typedef struct packed {
    logic [2:0]  kind;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 60;
  localparam vec_t VEC [NV] = '{
    '{K_RD,  8'h90, 32'h0,  32'h0,  4'd1},   // R1 pending zero
    '{K_RD,  8'h00, 32'h0,  32'h0,  4'd1},   // R1 direction zero
    '{K_IRQ, 8'h00, 32'h0,  32'h0,  4'd1},   // R1 irq low
    '{K_WR,  8'h00, 32'hFF, 32'h0,  4'd3},   // R3
    '{K_RD,  8'h00, 32'h0,  32'hFF, 4'd2},   // R2 readback
    '{K_OE,  8'h00, 32'h0,  32'hFF, 4'd3},   // R3
    '{K_OE,  8'h04, 32'h0,  32'h0,  4'd3},   // R3 other bank untouched
    '{K_WR,  8'h30, 32'h0F, 32'h0,  4'd4},   // R4 set
    '{K_OUT, 8'h00, 32'h0,  32'h0F, 4'd4},   // R4
    '{K_WR,  8'h40, 32'h03, 32'h0,  4'd4},   // R4 clear
    '{K_OUT, 8'h00, 32'h0,  32'h0C, 4'd4},   // R4
    '{K_RD,  8'h20, 32'h0,  32'h0C, 4'd5},   // R5 mixed readback
    '{K_WR,  8'h20, 32'hF0, 32'h0,  4'd4},   // R4 direct load
    '{K_OUT, 8'h00, 32'h0,  32'hF0, 4'd4},   // R4
    '{K_WR,  8'h08, 32'h01, 32'h0,  4'd2},   // R2 bank 2
    '{K_OE,  8'h08, 32'h0,  32'h01, 4'd2},   // R2
    '{K_WR,  8'h54, 32'h10, 32'h0,  4'd7},   // R7 rise en b1 bit4
    '{K_WR,  8'h64, 32'h20, 32'h0,  4'd7},   // R7 fall en b1 bit5
    '{K_PIN, 8'h04, 32'h30, 32'h0,  4'd7},   // R7 both rise
    '{K_RD,  8'h94, 32'h0,  32'h10, 4'd7},   // R7 only bit4
    '{K_RD,  8'hA4, 32'h0,  32'h10, 4'd11},  // R11 edge origin
    '{K_IRQ, 8'h00, 32'h0,  32'h1,  4'd12},  // R12
    '{K_PIN, 8'h04, 32'h00, 32'h0,  4'd7},   // R7 both fall
    '{K_RD,  8'h94, 32'h0,  32'h30, 4'd7},   // R7 bit5 added
    '{K_WR,  8'h94, 32'h10, 32'h0,  4'd8},   // R8
    '{K_RD,  8'h94, 32'h0,  32'h20, 4'd8},   // R8 only bit4 cleared
    '{K_IRQ, 8'h00, 32'h0,  32'h1,  4'd12},  // R12
    '{K_WR,  8'h94, 32'h20, 32'h0,  4'd8},   // R8
    '{K_RD,  8'h94, 32'h0,  32'h0,  4'd8},   // R8
    '{K_RD,  8'hA4, 32'h0,  32'h0,  4'd11},  // R11 cleared with pending
    '{K_IRQ, 8'h00, 32'h0,  32'h0,  4'd12},  // R12
    '{K_WR,  8'h18, 32'h02, 32'h0,  4'd6},   // R6 invert b2 bit1
    '{K_RD,  8'h28, 32'h0,  32'h02, 4'd6},   // R6
    '{K_WR,  8'h68, 32'h02, 32'h0,  4'd6},   // R6 fall en
    '{K_PIN, 8'h08, 32'h02, 32'h0,  4'd6},   // R6 pad rises, level falls
    '{K_RD,  8'h98, 32'h0,  32'h02, 4'd6},   // R6
    '{K_RD,  8'h28, 32'h0,  32'h0,  4'd6},   // R6
    '{K_WR,  8'h98, 32'h02, 32'h0,  4'd8},   // R8
    '{K_RD,  8'h98, 32'h0,  32'h0,  4'd8},   // R8
    '{K_WR,  8'h74, 32'h01, 32'h0,  4'd10},  // R10 high level b1 bit0
    '{K_PIN, 8'h04, 32'h01, 32'h0,  4'd10},  // R10
    '{K_RD,  8'h94, 32'h0,  32'h01, 4'd10},  // R10
    '{K_RD,  8'hA4, 32'h0,  32'h0,  4'd11},  // R11 level not edge
    '{K_WR,  8'h94, 32'h01, 32'h0,  4'd10},  // R10
    '{K_RD,  8'h94, 32'h0,  32'h01, 4'd10},  // R10 set again
    '{K_WR,  8'h74, 32'h00, 32'h0,  4'd10},  // R10
    '{K_WR,  8'h94, 32'h01, 32'h0,  4'd10},  // R10
    '{K_RD,  8'h94, 32'h0,  32'h0,  4'd10},  // R10
    '{K_WR,  8'h84, 32'h02, 32'h0,  4'd10},  // R10 low level bit1
    '{K_RD,  8'h94, 32'h0,  32'h02, 4'd10},  // R10
    '{K_WR,  8'h84, 32'h00, 32'h0,  4'd10},  // R10
    '{K_WR,  8'h94, 32'h02, 32'h0,  4'd10},  // R10
    '{K_RD,  8'h94, 32'h0,  32'h0,  4'd10},  // R10
    '{K_WR,  8'hB0, 32'hFFFFFFFF, 32'h0, 4'd2}, // R2 index 11
    '{K_RD,  8'hB0, 32'h0,  32'h0,  4'd2},   // R2
    '{K_WR,  8'h0C, 32'hFFFFFFFF, 32'h0, 4'd2}, // R2 bank 3
    '{K_RD,  8'h0C, 32'h0,  32'h0,  4'd2},   // R2
    '{K_WR,  8'h01, 32'hFF00, 32'h0, 4'd2},  // R2 misaligned
    '{K_RD,  8'h00, 32'h0,  32'hFF, 4'd2},   // R2 unchanged
    '{K_RD,  8'h01, 32'h0,  32'h0,  4'd2}    // R2
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      reg_addr = '0;
  logic            reg_we = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NB*BW-1:0] pad_in = '0;
  logic [NB*BW-1:0] pad_out, pad_oe;
  logic            irq;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  gpio_ctrl u_gpio_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .irq      (irq)
  );

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
      finish_up();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        K_WR: wr(VEC[i].addr, VEC[i].data);
        K_RD: begin
          rd(VEC[i].addr, v);
          chk(int'(VEC[i].req), v, VEC[i].exp, $sformatf("vector %0d read %h", i, VEC[i].addr));
        end
        K_PIN: begin
          pad_in[int'(VEC[i].addr[3:2])*BW +: BW] = VEC[i].data;
          repeat (4) @(negedge clk);
        end
        K_OUT: chk(int'(VEC[i].req), pad_out[int'(VEC[i].addr[3:2])*BW +: BW], VEC[i].exp,
                   $sformatf("vector %0d pad_out", i));
        K_OE: chk(int'(VEC[i].req), pad_oe[int'(VEC[i].addr[3:2])*BW +: BW], VEC[i].exp,
                  $sformatf("vector %0d pad_oe", i));
        K_IRQ: chk(int'(VEC[i].req), {31'd0, irq}, VEC[i].exp, $sformatf("vector %0d irq", i));
        default: ;
      endcase
      @(negedge clk);
    end

    // R5 / R7 / R9: exact latencies and set-beats-clear on bank 0 bit 9
    wr(8'h50, 32'h200);
    @(negedge clk);
    pad_in[9] = 1'b1;
    @(negedge clk);
    rd(8'h20, v);
    chk(5, v & 32'h200, 32'h0, "R5 readback after one edge");
    @(negedge clk);
    rd(8'h20, v);
    chk(5, v & 32'h200, 32'h200, "R5 readback after two edges");
    rd(8'h90, v);
    chk(7, v, 32'h0, "R7 pending not yet set");
    wr(8'h90, 32'h200);
    rd(8'h90, v);
    chk(9, v, 32'h200, "R9 event survives same-cycle clear");
    wr(8'h90, 32'h200);
    rd(8'h90, v);
    chk(8, v, 32'h0, "R8 later clear");

    // R1: reset mid-run returns everything to zero
    wr(8'h74, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rd(8'h00, v);
    chk(1, v, 32'h0, "R1 direction after reset");
    chk(1, pad_oe[31:0], 32'h0, "R1 pad_oe after reset");
    chk(1, pad_out[31:0], 32'h0, "R1 pad_out after reset");
    chk(1, {31'd0, irq}, 32'h0, "R1 irq after reset");
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(8'h94, v);
    chk(1, v, 32'h0, "R1 level enable cleared by reset");

    finish_up();
  end
endmodule